// File: doc/BRIEF.md
# Delayed-Event Third PWM Channel

This block derives an extra PWM waveform from a timer that has only two compare channels. Every compare-B-clear pulse from the timer arms a delay counter. That counter advances on the timer's count-clock tick through a selectable delay prescaler. Once the programmed number of delay ticks has elapsed, the block emits a one-cycle programmed event.

A three-input lookup table turns the compare-B-clear pulse and the programmed event into a waveform. Its third input is its own registered output fed back, so a suitable truth table makes it a set/reset latch. The pulse sets the output and the delayed event clears it. The delay value therefore sets the duty cycle of the third channel, and the timer's own period sets its frequency.

The delay value and the delay control word are sampled live. Software may rewrite them while the timer runs, and the pending delay follows the new values at its next delay tick.

Top module: `delayed_event_pwm`

## Requirements
- R1: While reset is asserted and directly after it, `prog_ev_o` and `pwm_o` are 0.
- R2: With the delay enabled and prescale /1, `prog_ev_o` rises just after the edge that takes the (value+1)-th count tick following a compare-B-clear pulse.
- R3: Control bits [5:4] set the delay prescaler to /1, /2, /4 or /8 (codes 0 to 3), so 0x0E gives /1 and 0x2E gives /4. The event then needs divider*(value+1) count ticks.
- R4: `prog_ev_o` is high for exactly one clock cycle per event.
- R5: A compare-B-clear pulse that arrives while a delay is pending restarts the count from zero, and no event is emitted in the cycle that follows it.
- R6: A delay value of 0 gives the shortest delay: one delay tick, which is divider count ticks.
- R7: A change to the delay value during a pending delay takes effect at once. If the new value is at or below the ticks already counted, the event fires at the next delay tick.
- R8: The delay runs only when control bits [3:0] equal 4'hE. Any other code produces no programmed event.
- R9: On each clock edge `pwm_o` takes the truth-table bit indexed by {compare-B-clear, programmed event, `pwm_o`}, with the compare pulse as the most significant bit.
- R10: With truth table 0xF2 the output is a latch. A compare pulse sets it, the programmed event alone clears it, and the output holds when neither is active. The high time is then value+2 clocks at /1 with a tick every cycle.
- R11: The delay counter does not advance in cycles without a count tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_clr_i | input | 1 | Compare-B-clear pulse from the timer |
| cnt_tick_i | input | 1 | Count-prescaler tick (one-cycle enable) |
| dly_ctrl_i | input | 8 | Delay control: [5:4] prescaler, [3:0] mode |
| dly_val_i | input | DLY_W | Delay value in delay ticks, minus one |
| lut_tt_i | input | 8 | Lookup-table truth table |
| prog_ev_o | output | 1 | Programmed event pulse |
| pwm_o | output | 1 | Third PWM waveform (lookup-table output) |

## Verification
The assertions assume that the compare pulse and the count tick are single-cycle strobes sampled on the rising clock edge. They also assume that the event-related checks matter only while the mode code selects the delay. The bench drives every input at the falling edge, keeps the tick low in the cycle of each compare pulse, and generates ticks from a fixed period so that tick counts are known. Truth tables are loaded while no event is in flight, except in the latch scenario, where the event is the intended clear.

// File: rtl/delayed_event_pwm.sv
module delayed_event_pwm #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_clr_i,
  input  logic             cnt_tick_i,
  input  logic [7:0]       dly_ctrl_i,
  input  logic [DLY_W-1:0] dly_val_i,
  input  logic [7:0]       lut_tt_i,
  output logic             prog_ev_o,
  output logic             pwm_o
);

  localparam logic [3:0] MODE_DELAY_EV = 4'hE;
  localparam int         PRE_W = 3;

  logic             mode_ok;
  logic [PRE_W-1:0] pre_lim;
  logic             pending;
  logic [PRE_W-1:0] pre_cnt;
  logic [DLY_W-1:0] dly_cnt;
  logic             arm;
  logic             dly_tick;
  logic             done;
  logic             fire;

  assign mode_ok  = dly_ctrl_i[3:0] == MODE_DELAY_EV;
  assign pre_lim  = PRE_W'((4'd1 << dly_ctrl_i[5:4]) - 4'd1);
  assign arm      = cmp_clr_i && mode_ok;
  assign dly_tick = pending && cnt_tick_i && !arm && (pre_cnt >= pre_lim);
  assign done     = dly_tick && (dly_cnt >= dly_val_i);
  assign fire     = done && mode_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      pre_cnt   <= '0;
      dly_cnt   <= '0;
      prog_ev_o <= 1'b0;
      pwm_o     <= 1'b0;
    end else begin
      prog_ev_o <= fire;
      pwm_o     <= lut_tt_i[{cmp_clr_i, prog_ev_o, pwm_o}];
      if (arm) begin
        pending <= 1'b1;
        pre_cnt <= '0;
        dly_cnt <= '0;
      end else if (pending && cnt_tick_i) begin
        if (pre_cnt >= pre_lim) begin
          pre_cnt <= '0;
          if (done) pending <= 1'b0;
          else      dly_cnt <= dly_cnt + 1'b1;
        end else begin
          pre_cnt <= pre_cnt + 1'b1;
        end
      end
    end
  end

  p_ev_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    prog_ev_o |=> !prog_ev_o);

  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_clr_i && dly_ctrl_i[3:0] == 4'hE) |=> !prog_ev_o);

  p_mode_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_ctrl_i[3:0] != 4'hE) |=> !prog_ev_o);

  p_no_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_tick_i |=> !prog_ev_o);

  p_latch_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_clr_i && lut_tt_i == 8'hF2) |=> pwm_o);

  p_latch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_clr_i && !prog_ev_o && lut_tt_i == 8'hF2) |=> (pwm_o == $past(pwm_o)));

endmodule

// File: tb/delayed_event_pwm_test.sv
module delayed_event_pwm_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] ctrl = 8'h0E;
  logic [7:0] val = 8'd0;
  logic [7:0] tt = 8'h00;
  logic       ev;
  logic       pwm;
  int         checks = 0;
  int         errors = 0;

  always #2 clk = ~clk;

  delayed_event_pwm #(.DLY_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .cmp_clr_i(cmp), .cnt_tick_i(tick),
    .dly_ctrl_i(ctrl), .dly_val_i(val), .lut_tt_i(tt),
    .prog_ev_o(ev), .pwm_o(pwm));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_cmp();
    @(negedge clk); cmp = 1'b1; tick = 1'b0;
    @(negedge clk); cmp = 1'b0;
  endtask

  // Count ticks given after a compare pulse until the event appears.
  task automatic measure(input int period, output int ticks, output bit pulse_ok);
    int cyc = 0;
    ticks = -1;
    pulse_ok = 1'b0;
    @(negedge clk); cmp = 1'b1; tick = 1'b0;
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk); cmp = 1'b0;
      if (ev) begin
        ticks = cyc;
        tick = 1'b0;
        @(negedge clk);
        pulse_ok = !ev;
        return;
      end
      tick = ((n % period) == period - 1);
      if (tick) cyc++;
    end
    ticks = -2;
  endtask

  task automatic t_reset();
    chk(ev == 1'b0, "R1 ev", ev, 0);
    chk(pwm == 1'b0, "R1 pwm", pwm, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(ev == 1'b0 && pwm == 1'b0, "R1 after release", {ev, pwm}, 0);
  endtask

  task automatic t_div1();
    int t; bit p;
    ctrl = 8'h0E; val = 8'd3; measure(1, t, p);
    chk(t == 4, "R2 /1 val3", t, 4);
    chk(p, "R4 single cycle", p, 1);
    val = 8'd0; measure(1, t, p);
    chk(t == 1, "R6 val0 /1", t, 1);
    val = 8'd20; measure(3, t, p);
    chk(t == 21, "R11 sparse ticks", t, 21);
  endtask

  task automatic t_prescale();
    int t; bit p;
    ctrl = 8'h2E; val = 8'd2; measure(1, t, p);
    chk(t == 12, "R3 /4 val2", t, 12);
    ctrl = 8'h1E; val = 8'd1; measure(2, t, p);
    chk(t == 4, "R3 /2 val1", t, 4);
    ctrl = 8'h3E; val = 8'd0; measure(1, t, p);
    chk(t == 8, "R6 val0 /8", t, 8);
    chk(p, "R4 single cycle /8", p, 1);
  endtask

  task automatic t_restart();
    int t = 0;
    ctrl = 8'h0E; val = 8'd5;
    pulse_cmp();
    tick = 1'b1;
    repeat (3) @(negedge clk);
    cmp = 1'b1; tick = 1'b0;
    @(negedge clk); cmp = 1'b0;
    chk(ev == 1'b0, "R5 no event after restart", ev, 0);
    for (int n = 0; n < 50 && !ev; n++) begin
      tick = 1'b1; t++;
      @(negedge clk);
    end
    tick = 1'b0;
    chk(t == 6, "R5 restart count", t, 6);
  endtask

  task automatic t_live();
    int t = 0;
    ctrl = 8'h0E; val = 8'd10;
    pulse_cmp();
    tick = 1'b1;
    for (int n = 0; n < 50 && !ev; n++) begin
      if (t == 3) val = 8'd5;
      t++;
      @(negedge clk);
    end
    tick = 1'b0;
    chk(t == 6, "R7 live value change", t, 6);
    val = 8'd8;
    pulse_cmp();
    tick = 1'b1; t = 0;
    for (int n = 0; n < 50 && !ev; n++) begin
      if (t == 5) val = 8'd2;
      t++;
      @(negedge clk);
    end
    tick = 1'b0;
    chk(t == 6, "R7 value below count", t, 6);
  endtask

  task automatic t_mode_off();
    int seen = 0;
    ctrl = 8'h0C; val = 8'd2;
    pulse_cmp();
    tick = 1'b1;
    for (int n = 0; n < 30; n++) begin
      @(negedge clk);
      if (ev) seen++;
    end
    tick = 1'b0;
    chk(seen == 0, "R8 mode off no event", seen, 0);
    ctrl = 8'h0E;
  endtask

  task automatic t_lut();
    @(negedge clk); tt = 8'hFF;
    @(negedge clk);
    chk(pwm == 1'b1, "R9 table all ones", pwm, 1);
    tt = 8'h00;
    @(negedge clk);
    chk(pwm == 1'b0, "R9 table all zeros", pwm, 0);
    tt = 8'h10; cmp = 1'b1;
    @(negedge clk); cmp = 1'b0;
    chk(pwm == 1'b1, "R9 index 4 (cmp only)", pwm, 1);
    @(negedge clk);
    chk(pwm == 1'b0, "R9 index 1 (fb only)", pwm, 0);
    tt = 8'h00;
    @(negedge clk);
  endtask

  task automatic t_latch();
    int high = 0;
    bit ev_prev = 1'b0;
    ctrl = 8'h0E; val = 8'd4; tt = 8'hF2;
    @(negedge clk); cmp = 1'b1; tick = 1'b0;
    @(negedge clk); cmp = 1'b0; tick = 1'b1;
    for (int n = 0; n < 40; n++) begin
      if (pwm) high++;
      if (ev_prev) break;
      ev_prev = ev;
      @(negedge clk);
    end
    tick = 1'b0;
    chk(high == 6, "R10 latch high time", high, 6);
    @(negedge clk);
    chk(pwm == 1'b0, "R10 cleared by event", pwm, 0);
    repeat (3) @(negedge clk);
    chk(pwm == 1'b0, "R10 holds low", pwm, 0);
    tt = 8'h00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    t_div1();
    t_prescale();
    t_restart();
    t_live();
    t_mode_off();
    t_lut();
    t_latch();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule